// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that gives the rest of a chip a small bank of byte-wide control registers. It watches SCL and SDA as ordinary inputs sampled on the system clock. It answers the bus only by pulling SDA low through an open-drain output enable. It never holds SCL low and never takes part in arbitration.

The block's 7-bit bus address is a fixed base plus an index between 0 and 8. Two three-level strap inputs select the index. Each strap is presented as a 2-bit code, and the block samples both straps only while reset is held.

A controller writes by addressing the target, sending one byte that selects a register, and then sending the bytes to store there. A controller reads by addressing the target for reading. The target then returns the register that the last pointer byte selected, so the usual sequence is a pointer write, a repeated START, and then the read.

Top module: `strap_i2c_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Both are judged on copies of the lines synchronized to the system clock. After a STOP the target releases SDA and ignores the bus until the next START.
- R2: The address byte arrives MSB first, and bit 0 is the direction bit (0 = write, 1 = read). When bits 7..1 equal the target's address, the target pulls SDA low for the ninth clock. For any other address it leaves SDA released.
- R3: The address is computed as follows:
  - Each strap code is decoded as 2'b00 = level 0 (tied low), 2'b01 = level 1 (open), 2'b10 = level 2 (tied high), and 2'b11 = level 1.
  - The index is 3*level(strap_hi_i) + level(strap_lo_i).
  - The 7-bit address is BASE_ADDR7 + index, with BASE_ADDR7 = 7'h60 by default.
  - In 8-bit form, the write address is 0xC0 + 2*index and the read address is one more than that.
- R4: The straps are sampled only while rst_ni is low. Changing them after reset does not change which address is acknowledged.
- R5: The general call address (byte 0x00) is never acknowledged.
- R6: In a write transfer, every data byte is acknowledged. The first data byte after the address loads the register pointer. Each later byte in the same transfer overwrites the register at that pointer, and the pointer does not advance.
- R7: A written byte updates regs_o only after the falling edge that ends its ninth clock, so regs_o is unchanged while that acknowledge clock is high. A byte that is cut short by a START or STOP changes no register.
- R8: A read returns the pointed register MSB first. The same register is repeated for every byte the controller acknowledges. SDA changes only while SCL is low.
- R9: The target releases SDA during the acknowledge clock of each read byte. A NACK from the controller makes the target release SDA until the next START.
- R10: A repeated START at any point drops the byte in progress and restarts address reception. The register pointer is kept.
- R11: When the pointer is at or above NUM_REGS (default 4), writes change no register and reads return 0x00.
- R12: Reset clears every register and the pointer to 0 and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Active-low reset; the straps are sampled while it is low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_hi_i | input | 2 | Upper strap code (00 low, 01 open, 10 high, 11 open) |
| strap_lo_i | input | 2 | Lower strap code, same encoding |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | NUM_REGS*DATA_W | Register contents; register r is at bits [r*8 +: 8] |

## Verification
The risky coincidence is a byte's commit and the end of its transfer. On the falling edge that closes a data byte's ninth clock, the target both releases its acknowledge and writes the register, and a START or STOP can arrive right after that edge or part way through the next byte. The bench captures regs_o while the acknowledge clock is still high and again after the edge. It then cuts a later byte after four bits with a repeated START and checks that the pointed register kept its old value. A checker property ties every change of regs_o to a synchronized SCL fall two cycles earlier.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;

   // byte engine states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_BYTE,
      ST_WR_ACK,
      ST_RD_BYTE,
      ST_RD_ACK
   } tgt_state_e;

   // bus events after synchronization
   typedef struct packed {
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } line_evt_t;

   localparam int unsigned STRAP_LEVELS = 3;
   localparam int unsigned MAX_INDEX    = STRAP_LEVELS * STRAP_LEVELS - 1;

   // three-level strap code to level; unused code reads as open
   function automatic logic [1:0] strap_level(input logic [1:0] code);
      case (code)
         2'b00:   return 2'd0;
         2'b10:   return 2'd2;
         default: return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
   import strap_i2c_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      scl_i,
   input  logic      sda_i,
   output line_evt_t evt_o
);

   localparam int unsigned TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] scl_q;
   logic [SYNC_STAGES-1:0] sda_q;
   logic                   scl_d;
   logic                   sda_d;
   logic                   scl_now;
   logic                   sda_now;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
         sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
         scl_d <= scl_q[TOP];
         sda_d <= sda_q[TOP];
      end
   end

   assign scl_now = scl_q[TOP];
   assign sda_now = sda_q[TOP];

   always_comb begin
      evt_o.sda      = sda_now;
      evt_o.scl_rise = scl_now & ~scl_d;
      evt_o.scl_fall = ~scl_now & scl_d;
      evt_o.start    = scl_now & scl_d & sda_d & ~sda_now;
      evt_o.stop     = scl_now & scl_d & ~sda_d & sda_now;
   end

endmodule

// File: rtl/strap_addr_latch.sv
module strap_addr_latch
   import strap_i2c_pkg::*;
#(
   parameter logic [6:0] BASE_ADDR7 = 7'h60
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] strap_hi_i,
   input  logic [1:0] strap_lo_i,
   output logic [6:0] dev_addr_o
);

   logic [1:0] lvl_hi;
   logic [1:0] lvl_lo;
   logic [3:0] index;

   assign lvl_hi = strap_level(strap_hi_i);
   assign lvl_lo = strap_level(strap_lo_i);
   assign index  = 4'(lvl_hi) * 4'(STRAP_LEVELS) + 4'(lvl_lo);

   // capture only while reset is held; frozen afterwards
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         dev_addr_o <= BASE_ADDR7 + 7'(index);
      end
   end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PTR_W    = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       wr_en_i,
   input  logic [PTR_W-1:0]           ptr_i,
   input  logic [DATA_W-1:0]          wr_data_i,
   output logic [DATA_W-1:0]          rd_data_o,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);

   localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   logic              in_range;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] mem [NUM_REGS];

   // a pointer that spans the whole bank needs no range check
   if (NUM_REGS == (1 << PTR_W)) begin : g_full_span
      assign in_range = 1'b1;
   end else begin : g_partial_span
      assign in_range = (ptr_i < PTR_W'(NUM_REGS));
   end

   assign idx = ptr_i[IDX_W-1:0];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mem[r] <= '0;
         end else if (wr_en_i && in_range && (idx == IDX_W'(r))) begin
            mem[r] <= wr_data_i;
         end
      end
      assign regs_o[r*DATA_W +: DATA_W] = mem[r];
   end

   assign rd_data_o = in_range ? mem[idx] : '0;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
   import strap_i2c_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  line_evt_t         evt_i,
   input  logic [6:0]        dev_addr_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              sda_oe_o,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] ptr_o,
   output logic [DATA_W-1:0] wr_data_o
);

   localparam logic [3:0] BITS      = 4'(DATA_W);
   localparam logic [3:0] LAST_SENT = 4'(DATA_W - 1);

   tgt_state_e        state_q;
   logic [3:0]        cnt_q;
   logic [DATA_W-1:0] shift_q;
   logic              rw_q;
   logic              first_q;
   logic              nack_q;
   logic              addr_hit;

   assign addr_hit  = (shift_q[7:1] == dev_addr_i) && (shift_q[7:1] != 7'd0);
   assign wr_data_o = shift_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         shift_q  <= '0;
         rw_q     <= 1'b0;
         first_q  <= 1'b0;
         nack_q   <= 1'b0;
         sda_oe_o <= 1'b0;
         wr_en_o  <= 1'b0;
         ptr_o    <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (evt_i.start) begin
            state_q  <= ST_ADDR;
            cnt_q    <= '0;
            sda_oe_o <= 1'b0;
         end else if (evt_i.stop) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sda_oe_o <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR, ST_WR_BYTE: begin
                  if (evt_i.scl_rise && (cnt_q != BITS)) begin
                     shift_q <= {shift_q[DATA_W-2:0], evt_i.sda};
                     cnt_q   <= cnt_q + 4'd1;
                  end else if (evt_i.scl_fall && (cnt_q == BITS)) begin
                     cnt_q <= '0;
                     if (state_q == ST_ADDR) begin
                        if (addr_hit) begin
                           rw_q     <= shift_q[0];
                           sda_oe_o <= 1'b1;
                           state_q  <= ST_ADDR_ACK;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else begin
                        sda_oe_o <= 1'b1;
                        state_q  <= ST_WR_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (evt_i.scl_fall) begin
                     first_q <= 1'b1;
                     if (rw_q) begin
                        shift_q  <= rd_data_i;
                        sda_oe_o <= ~rd_data_i[DATA_W-1];
                        state_q  <= ST_RD_BYTE;
                     end else begin
                        sda_oe_o <= 1'b0;
                        state_q  <= ST_WR_BYTE;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (evt_i.scl_fall) begin
                     sda_oe_o <= 1'b0;
                     state_q  <= ST_WR_BYTE;
                     first_q  <= 1'b0;
                     if (first_q) begin
                        ptr_o <= shift_q;
                     end else begin
                        wr_en_o <= 1'b1;
                     end
                  end
               end
               ST_RD_BYTE: begin
                  if (evt_i.scl_fall) begin
                     if (cnt_q == LAST_SENT) begin
                        cnt_q    <= '0;
                        sda_oe_o <= 1'b0;
                        state_q  <= ST_RD_ACK;
                     end else begin
                        cnt_q    <= cnt_q + 4'd1;
                        shift_q  <= {shift_q[DATA_W-2:0], 1'b0};
                        sda_oe_o <= ~shift_q[DATA_W-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (evt_i.scl_rise) begin
                     nack_q <= evt_i.sda;
                  end else if (evt_i.scl_fall) begin
                     if (nack_q) begin
                        state_q <= ST_IDLE;
                     end else begin
                        shift_q  <= rd_data_i;
                        sda_oe_o <= ~rd_data_i[DATA_W-1];
                        state_q  <= ST_RD_BYTE;
                     end
                  end
               end
               default: begin
                  cnt_q <= '0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
   import strap_i2c_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NUM_REGS    = 4,
   parameter int unsigned DATA_W      = 8,
   parameter logic [6:0]  BASE_ADDR7  = 7'h60
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       scl_i,
   input  logic                       sda_i,
   input  logic [1:0]                 strap_hi_i,
   input  logic [1:0]                 strap_lo_i,
   output logic                       sda_oe_o,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);

   localparam int unsigned PTR_W = DATA_W;

   if (DATA_W != 8) begin : g_bad_width
      $error("DATA_W must be 8 for byte transfers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((NUM_REGS < 1) || (NUM_REGS > (1 << PTR_W))) begin : g_bad_regs
      $error("NUM_REGS out of pointer range");
   end
   if ((int'(BASE_ADDR7) + int'(MAX_INDEX)) > 127) begin : g_bad_base
      $error("BASE_ADDR7 leaves no room for all strap indices");
   end

   line_evt_t         line_evt;
   logic [6:0]        dev_addr;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] ptr;
   logic [DATA_W-1:0] wr_data;
   logic              wr_en;

   i2c_line_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt_o (line_evt)
   );

   strap_addr_latch #(
      .BASE_ADDR7(BASE_ADDR7)
   ) u_addr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strap_hi_i(strap_hi_i),
      .strap_lo_i(strap_lo_i),
      .dev_addr_o(dev_addr)
   );

   i2c_target_fsm #(
      .DATA_W(DATA_W)
   ) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (line_evt),
      .dev_addr_i(dev_addr),
      .rd_data_i (rd_data),
      .sda_oe_o  (sda_oe_o),
      .wr_en_o   (wr_en),
      .ptr_o     (ptr),
      .wr_data_o (wr_data)
   );

   i2c_reg_bank #(
      .NUM_REGS(NUM_REGS),
      .DATA_W  (DATA_W),
      .PTR_W   (PTR_W)
   ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en),
      .ptr_i    (ptr),
      .wr_data_i(wr_data),
      .rd_data_o(rd_data),
      .regs_o   (regs_o)
   );

endmodule

// File: rtl/strap_i2c_target_chk.sv
module strap_i2c_target_chk #(
   parameter int unsigned NUM_REGS   = 4,
   parameter int unsigned DATA_W     = 8,
   parameter logic [6:0]  BASE_ADDR7 = 7'h60
) (
   input logic                       clk_i,
   input logic                       rst_ni,
   input logic                       scl_fall_i,
   input logic                       start_i,
   input logic                       stop_i,
   input logic [6:0]                 dev_addr_i,
   input logic                       sda_oe_i,
   input logic [NUM_REGS*DATA_W-1:0] regs_i
);

   // R1: a STOP leaves SDA released
   p_release_on_stop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> !sda_oe_i);

   // R8: SDA drive moves only after a SCL fall or a START/STOP
   p_sda_moves_when_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(scl_fall_i || start_i || stop_i) |=> $stable(sda_oe_i));

   // R3: the captured address lies in the nine-entry window
   p_addr_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dev_addr_i >= BASE_ADDR7) && (dev_addr_i <= BASE_ADDR7 + 7'd8));

   // R4: the address is frozen once reset is released
   p_strap_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> $stable(dev_addr_i));

   // R7: registers change only two cycles after a SCL fall
   p_commit_after_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(regs_i) |-> $past(scl_fall_i, 2));

endmodule

bind strap_i2c_target strap_i2c_target_chk #(
   .NUM_REGS  (NUM_REGS),
   .DATA_W    (DATA_W),
   .BASE_ADDR7(BASE_ADDR7)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .scl_fall_i(line_evt.scl_fall),
   .start_i   (line_evt.start),
   .stop_i    (line_evt.stop),
   .dev_addr_i(dev_addr),
   .sda_oe_i  (sda_oe_o),
   .regs_i    (regs_o)
);

// File: tb/strap_i2c_target_bench.sv
module strap_i2c_target_bench;

   localparam int Q = 8;   // quarter bus period in system clocks

   logic        clk;
   logic        rst_n;
   logic        scl_m;
   logic        sda_m;
   logic        sda_bus;
   logic [1:0]  strap_hi;
   logic [1:0]  strap_lo;
   logic        sda_oe;
   logic [31:0] regs;

   int n_cmp = 0;
   int n_err = 0;

   logic [7:0]  rd;
   logic        ack;
   logic        oe_ack;
   logic [31:0] snap;

   // {strap_hi, strap_lo, expected 7-bit address}
   localparam logic [10:0] VEC [10] = '{
      {2'b00, 2'b00, 7'h60}, {2'b00, 2'b01, 7'h61}, {2'b00, 2'b10, 7'h62},
      {2'b01, 2'b00, 7'h63}, {2'b01, 2'b01, 7'h64}, {2'b01, 2'b10, 7'h65},
      {2'b10, 2'b00, 7'h66}, {2'b10, 2'b01, 7'h67}, {2'b10, 2'b10, 7'h68},
      {2'b11, 2'b11, 7'h64}
   };

   localparam logic [6:0] DEV = 7'h65;   // straps hi=01, lo=10

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   strap_i2c_target u_strap_i2c_target (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_bus),
      .strap_hi_i(strap_hi),
      .strap_lo_i(strap_lo),
      .sda_oe_o  (sda_oe),
      .regs_o    (regs)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] hi, input logic [1:0] lo);
      rst_n    = 1'b0;
      strap_hi = hi;
      strap_lo = lo;
      scl_m    = 1'b1;
      sda_m    = 1'b1;
      tick(4);
      rst_n = 1'b1;
      tick(4);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      acked = ~sda_bus;
      snap  = regs;
      tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input logic m_ack, output logic [7:0] d, output logic oe_in_ack);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl_m = 1'b1; tick(Q);
         d[i] = sda_bus; tick(Q);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = ~m_ack; tick(Q);
      scl_m = 1'b1; tick(Q);
      oe_in_ack = sda_oe; tick(Q);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic write_reg(input logic [7:0] p, input logic [7:0] d);
      bus_start();
      send_byte({DEV, 1'b0}, ack); chk("R2 write address ack", 32'(ack), 32'd1);
      send_byte(p, ack);           chk("R6 pointer byte ack", 32'(ack), 32'd1);
      send_byte(d, ack);           chk("R6 data byte ack", 32'(ack), 32'd1);
      bus_stop();
   endtask

   task automatic read_reg(input logic [7:0] p, output logic [7:0] d);
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(p, ack);
      bus_start();
      send_byte({DEV, 1'b1}, ack); chk("R10 read address ack after restart", 32'(ack), 32'd1);
      recv_byte(1'b0, d, oe_ack);
      bus_stop();
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      scl_m    = 1'b1;
      sda_m    = 1'b1;
      strap_hi = 2'b00;
      strap_lo = 2'b00;

      // R12 reset state
      do_reset(2'b00, 2'b00);
      chk("R12 registers after reset", regs, 32'h0);
      chk("R12 SDA released after reset", 32'(sda_oe), 32'd0);

      // R3 strap table walk; R2 match and neighbour miss
      for (int v = 0; v < 10; v++) begin
         do_reset(VEC[v][10:9], VEC[v][8:7]);
         bus_start();
         send_byte({VEC[v][6:0], 1'b0}, ack);
         chk("R3 strapped address ack", 32'(ack), 32'd1);
         bus_stop();
         chk("R1 SDA released after STOP", 32'(sda_oe), 32'd0);
         bus_start();
         send_byte({VEC[v][6:0] + 7'd1, 1'b0}, ack);
         chk("R2 other address no ack", 32'(ack), 32'd0);
         bus_stop();
      end

      // R4 straps changed after reset
      do_reset(2'b01, 2'b10);
      strap_hi = 2'b00;
      strap_lo = 2'b00;
      tick(4);
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      chk("R4 latched address still acked", 32'(ack), 32'd1);
      bus_stop();
      bus_start();
      send_byte({7'h60, 1'b0}, ack);
      chk("R4 new strap address ignored", 32'(ack), 32'd0);
      bus_stop();

      // R5 general call
      bus_start();
      send_byte(8'h00, ack);
      chk("R5 general call no ack", 32'(ack), 32'd0);
      bus_stop();

      // R6 / R7 write and commit timing
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h02, ack);
      send_byte(8'hA5, ack);
      chk("R7 register unchanged during ack clock", snap, 32'h0);
      chk("R7 register written after ack clock", regs, 32'h00A5_0000);
      bus_stop();

      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h01, ack);
      send_byte(8'h11, ack);
      send_byte(8'h3C, ack);
      chk("R6 second byte ack", 32'(ack), 32'd1);
      bus_stop();
      chk("R6 pointer does not advance", regs, 32'h00A5_3C00);

      write_reg(8'h03, 8'h81);
      chk("R6 register 3 written", regs, 32'h81A5_3C00);

      // R8 / R9 / R10 reads with repeated START
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h02, ack);
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      chk("R10 restart read address ack", 32'(ack), 32'd1);
      recv_byte(1'b1, rd, oe_ack);
      chk("R8 read first byte", 32'(rd), 32'hA5);
      chk("R9 released in read ack slot", 32'(oe_ack), 32'd0);
      recv_byte(1'b0, rd, oe_ack);
      chk("R8 read repeats same register", 32'(rd), 32'hA5);
      chk("R9 released in final ack slot", 32'(oe_ack), 32'd0);
      tick(2*Q);
      chk("R9 no drive after NACK", 32'(sda_oe), 32'd0);
      bus_stop();

      read_reg(8'h03, rd);
      chk("R8 read register 3", 32'(rd), 32'h81);
      read_reg(8'h01, rd);
      chk("R8 read register 1", 32'(rd), 32'h3C);

      // R7 / R10 byte cut short by repeated START
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h02, ack);
      send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b1);
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      chk("R10 address after aborted byte", 32'(ack), 32'd1);
      bus_stop();
      chk("R7 aborted byte not written", regs, 32'h81A5_3C00);

      // R11 pointer out of range
      write_reg(8'h07, 8'h99);
      chk("R11 out-of-range write ignored", regs, 32'h81A5_3C00);
      read_reg(8'h07, rd);
      chk("R11 out-of-range read is zero", 32'(rd), 32'h00);

      // R12 reset clears registers and pointer
      do_reset(2'b01, 2'b10);
      chk("R12 registers cleared", regs, 32'h0);
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      recv_byte(1'b0, rd, oe_ack);
      chk("R12 pointer back to 0", 32'(rd), 32'h00);
      bus_stop();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

endmodule